// File: doc/BRIEF.md
# PCI Inbound Window Address Translator

This block sits on the target side of a PCI host bridge. It compares each inbound PCI memory address with six programmable windows. On a hit it gives back the local system-bus address the access should go to. Each window has three registers of its own: a size register whose upper bits form an address mask, a base address on the PCI side and a remap base on the local side. An address that lands in a window is therefore moved to a new location, not passed through unchanged. The size register also carries a prefetchable flag, which is reported with the hit.

Software programs the windows through a flat register port: a write strobe, a window index, a field select and a data word. Reads are combinational from the same index and field. Lookups are presented as an address with a valid strobe. One clock later the block returns a hit flag, the index of the winning window, the translated address and the prefetch attribute.

Top module: `pci_bar_xlate`

## Requirements
- R1: The register port addresses a window with `cfg_win` (0 to 5) and a field with `cfg_fld`: 0 is size, 1 is PCI base, 2 is local base. A write with `cfg_we` high takes effect at the clock edge, and `cfg_rdata` returns the addressed field. Field 3, and window indexes 6 and 7, read as zero and ignore writes.
- R2: After reset every register of every window reads zero, and no lookup hits until a window is programmed.
- R3: A window's mask is its size register with bits 3:0 forced to zero. A window whose mask is zero is disabled and never hits, even when bits 3:0 of its size register are set.
- R4: An enabled window hits when `(addr & mask) == (pci_base & mask)`.
- R5: On a hit, the translated address is `(local_base & mask) | (addr & ~mask)`.
- R6: On a hit, `out_pref` equals bit 3 of the winning window's size register. The value 0xF0000008 describes a 256 MB prefetchable window.
- R7: When several windows hit, the lowest-numbered one wins.
- R8: Outputs are registered. `out_valid` and the lookup result appear in the cycle after `in_valid`/`in_addr` are sampled.
- R9: A miss, or a cycle without `in_valid`, gives `out_hit`=0, `out_idx`=0, `out_addr`=0 and `out_pref`=0.
- R10: A lookup sampled on the same edge as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for register access |
| cfg_fld | input | 2 | Field select: 0 size, 1 PCI base, 2 local base |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the addressed field |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 32 | PCI address to translate |
| out_valid | output | 1 | Lookup result valid, one cycle after the request |
| out_hit | output | 1 | Address fell inside an enabled window |
| out_idx | output | 3 | Index of the winning window |
| out_addr | output | 32 | Translated local address |
| out_pref | output | 1 | Winning window is prefetchable |

## Verification
The bench targets overlapping windows, where a design with reversed priority would report window 1 and its remap for an address that window 0 also covers. It also covers a size register holding only the prefetch flag: a design that tested the whole register rather than the mask would treat that window as enabled with a zero mask and catch every address. Two further cases are a write and a lookup on the same edge, where a design that forwards the new value would translate through a base that was not yet in effect, and writes to window indexes 6 and 7, which a sloppy decoder could alias onto real windows. Randomized programming with addresses drawn from the programmed bases exercises many mask widths and shows whether offset bits leak into the remapped upper bits.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
   typedef enum logic [1:0] {
      FLD_SIZE  = 2'd0,
      FLD_PBASE = 2'd1,
      FLD_LBASE = 2'd2,
      FLD_RSVD  = 2'd3
   } pbx_fld_e;
endpackage

// File: rtl/pbx_regfile.sv
module pbx_regfile
   import pbx_pkg::*;
#(
   parameter int NWIN   = 6,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             sel_win,
   input  pbx_fld_e                     sel_fld,
   input  logic [ADDR_W-1:0]            wdata,
   output logic [NWIN-1:0][ADDR_W-1:0]  size_o,
   output logic [NWIN-1:0][ADDR_W-1:0]  pbase_o,
   output logic [NWIN-1:0][ADDR_W-1:0]  lbase_o,
   output logic [ADDR_W-1:0]            rdata
);
   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic sel_here;
      assign sel_here = wr_en && (sel_win == IDX_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_o[w]  <= '0;
            pbase_o[w] <= '0;
            lbase_o[w] <= '0;
         end else if (sel_here) begin
            case (sel_fld)
               FLD_SIZE:  size_o[w]  <= wdata;
               FLD_PBASE: pbase_o[w] <= wdata;
               FLD_LBASE: lbase_o[w] <= wdata;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (sel_win == IDX_W'(i)) begin
            case (sel_fld)
               FLD_SIZE:  rdata = size_o[i];
               FLD_PBASE: rdata = pbase_o[i];
               FLD_LBASE: rdata = lbase_o[i];
               default:   rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/pbx_win_match.sv
module pbx_win_match #(
   parameter int ADDR_W    = 32,
   parameter int ATTR_BITS = 4,
   parameter int PREF_BIT  = 3
) (
   input  logic [ADDR_W-1:0] size_i,
   input  logic [ADDR_W-1:0] pbase_i,
   input  logic [ADDR_W-1:0] lbase_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] xaddr_o,
   output logic              pref_o
);
   logic [ADDR_W-1:0] mask;
   logic              enabled;

   assign mask    = {size_i[ADDR_W-1:ATTR_BITS], {ATTR_BITS{1'b0}}};
   assign enabled = |mask;
   assign hit_o   = enabled && (((addr_i ^ pbase_i) & mask) == '0);
   assign xaddr_o = (lbase_i & mask) | (addr_i & ~mask);
   assign pref_o  = size_i[PREF_BIT];
endmodule

// File: rtl/pbx_prio.sv
module pbx_prio #(
   parameter int NWIN  = 6,
   parameter int IDX_W = 3
) (
   input  logic [NWIN-1:0]  req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pci_bar_xlate.sv
module pci_bar_xlate
   import pbx_pkg::*;
#(
   parameter int NWIN      = 6,
   parameter int ADDR_W    = 32,
   parameter int ATTR_BITS = 4,
   parameter int PREF_BIT  = 3,
   localparam int IDX_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_win,
   input  logic [1:0]        cfg_fld,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic              out_hit,
   output logic [IDX_W-1:0]  out_idx,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_pref
);
   if (NWIN < 1) begin : g_bad_nwin
      $error("pci_bar_xlate: NWIN must be at least 1");
   end
   if (ATTR_BITS < 1 || ATTR_BITS >= ADDR_W) begin : g_bad_attr
      $error("pci_bar_xlate: ATTR_BITS out of range");
   end
   if (PREF_BIT >= ATTR_BITS) begin : g_bad_pref
      $error("pci_bar_xlate: PREF_BIT must lie in the attribute bits");
   end

   logic [NWIN-1:0][ADDR_W-1:0] size_w, pbase_w, lbase_w, xaddr_w;
   logic [NWIN-1:0]             hit_w, pref_w;
   logic                        any_hit;
   logic [IDX_W-1:0]            win_sel;

   pbx_regfile #(.NWIN(NWIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .sel_win (cfg_win),
      .sel_fld (pbx_fld_e'(cfg_fld)),
      .wdata   (cfg_wdata),
      .size_o  (size_w),
      .pbase_o (pbase_w),
      .lbase_o (lbase_w),
      .rdata   (cfg_rdata)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_match
      pbx_win_match #(.ADDR_W(ADDR_W), .ATTR_BITS(ATTR_BITS), .PREF_BIT(PREF_BIT)) u_m (
         .size_i  (size_w[w]),
         .pbase_i (pbase_w[w]),
         .lbase_i (lbase_w[w]),
         .addr_i  (in_addr),
         .hit_o   (hit_w[w]),
         .xaddr_o (xaddr_w[w]),
         .pref_o  (pref_w[w])
      );
   end

   pbx_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) u_prio (
      .req_i (hit_w),
      .any_o (any_hit),
      .idx_o (win_sel)
   );

   logic take;
   assign take = in_valid && any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_idx   <= '0;
         out_addr  <= '0;
         out_pref  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_hit   <= take;
         out_idx   <= take ? win_sel : '0;
         out_addr  <= take ? xaddr_w[win_sel] : '0;
         out_pref  <= take ? pref_w[win_sel] : 1'b0;
      end
   end
endmodule

// File: rtl/pbx_chk.sv
module pbx_chk #(
   parameter int NWIN   = 6,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic              out_hit,
   input logic [IDX_W-1:0]  out_idx,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_pref
);
   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_hit);
   // R9
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_hit |-> (out_addr == '0 && out_idx == '0 && !out_pref));
   // R1
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> (int'(out_idx) < NWIN));
endmodule

bind pci_bar_xlate pbx_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_hit   (out_hit),
   .out_idx   (out_idx),
   .out_addr  (out_addr),
   .out_pref  (out_pref)
);

// File: tb/sim_pci_bar_xlate.sv
`timescale 1ns/1ps
module sim_pci_bar_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_win = '0;
   logic [1:0]  cfg_fld = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic        out_valid, out_hit, out_pref;
   logic [2:0]  out_idx;
   logic [31:0] out_addr;

   int checks = 0;
   int errors = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pci_bar_xlate u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_fld(cfg_fld),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_addr(in_addr),
      .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx), .out_addr(out_addr),
      .out_pref(out_pref)
   );

   // behavioural reference
   logic [31:0] msize [6];
   logic [31:0] mpb [6];
   logic [31:0] mlb [6];
   logic        e_valid, e_hit, e_pref;
   int          e_idx;
   logic [31:0] e_addr;

   function automatic void ref_lookup(input logic [31:0] a, output logic h, output int idx,
                                      output logic [31:0] x, output logic p);
      logic [31:0] m;
      h = 1'b0; idx = 0; x = '0; p = 1'b0;
      for (int w = 0; w < 6; w++) begin
         m = msize[w] & 32'hFFFF_FFF0;
         if (!h && m != 0 && ((a & m) == (mpb[w] & m))) begin
            h = 1'b1; idx = w; x = (mlb[w] & m) | (a & ~m); p = msize[w][3];
         end
      end
   endfunction

   function automatic logic [31:0] ref_read(input int w, input int f);
      if (w > 5) return '0;
      case (f)
         0: return msize[w];
         1: return mpb[w];
         2: return mlb[w];
         default: return '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < 6; w++) begin msize[w] = '0; mpb[w] = '0; mlb[w] = '0; end
         e_valid = 0; e_hit = 0; e_idx = 0; e_addr = '0; e_pref = 0;
      end else begin
         // R10: lookup uses values before this edge's write
         e_valid = in_valid;
         if (in_valid) ref_lookup(in_addr, e_hit, e_idx, e_addr, e_pref);
         else begin e_hit = 0; e_idx = 0; e_addr = '0; e_pref = 0; end
         if (cfg_we && cfg_win < 6) begin
            case (cfg_fld)
               2'd0: msize[cfg_win] = cfg_wdata;
               2'd1: mpb[cfg_win] = cfg_wdata;
               2'd2: mlb[cfg_win] = cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #2;
      if (running) begin
         string tag;
         logic [31:0] er;
         tag = !e_valid ? "R8" : (e_hit ? "R5" : "R9");
         checks++;
         if (out_valid !== e_valid || out_hit !== e_hit || int'(out_idx) != e_idx ||
             out_addr !== e_addr || out_pref !== e_pref) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b i=%0d a=%h p=%0b exp v=%0b h=%0b i=%0d a=%h p=%0b",
                     tag, out_valid, out_hit, out_idx, out_addr, out_pref,
                     e_valid, e_hit, e_idx, e_addr, e_pref);
         end
         er = ref_read(int'(cfg_win), int'(cfg_fld));
         checks++;
         if (cfg_rdata !== er) begin
            errors++;
            $display("FAIL R1: rdata win=%0d fld=%0d got %h exp %h", cfg_win, cfg_fld, cfg_rdata, er);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input int w, input int f, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_win = 3'(w); cfg_fld = 2'(f); cfg_wdata = d; in_valid = 0;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic look(input logic [31:0] a);
      @(negedge clk);
      in_valid = 1; in_addr = a;
      @(negedge clk);
      in_valid = 0;
      #3;
   endtask

   task automatic rd(input string tag, input int w, input int f, input logic [31:0] exp);
      @(negedge clk);
      cfg_win = 3'(w); cfg_fld = 2'(f);
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung exp finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R2 reset valid", {31'd0, out_valid}, 32'd0);
      rst_n = 1;
      running = 1;
      rd("R2 reset size", 0, 0, 32'd0);
      rd("R2 reset lbase", 5, 2, 32'd0);
      look(32'h0000_0000);
      chk("R2 no hit", {31'd0, out_hit}, 32'd0);

      // window 0: 256 MB prefetchable
      wr(0, 0, 32'hF000_0008); wr(0, 1, 32'h4000_0000); wr(0, 2, 32'h0000_0000);
      look(32'h4123_4567);
      chk("R4 hit", {31'd0, out_hit}, 32'd1);
      chk("R5 addr", out_addr, 32'h0123_4567);
      chk("R6 pref", {31'd0, out_pref}, 32'd1);
      look(32'h5123_4567);
      chk("R9 miss addr", out_addr, 32'd0);

      // window 2: 64 KB not prefetchable
      wr(2, 0, 32'hFFFF_0000); wr(2, 1, 32'h8001_0000); wr(2, 2, 32'h1234_0000);
      look(32'h8001_ABCD);
      chk("R5 win2 addr", out_addr, 32'h1234_ABCD);
      chk("R4 win2 idx", {29'd0, out_idx}, 32'd2);
      chk("R6 win2 pref", {31'd0, out_pref}, 32'd0);

      // overlap: window 1 inside window 0
      wr(1, 0, 32'hFFF0_0000); wr(1, 1, 32'h4010_0000); wr(1, 2, 32'h2000_0000);
      look(32'h4010_0010);
      chk("R7 lowest wins", {29'd0, out_idx}, 32'd0);
      wr(0, 0, 32'h0000_0000);
      look(32'h4010_0010);
      chk("R3 disabled idx", {29'd0, out_idx}, 32'd1);
      chk("R5 win1 addr", out_addr, 32'h2000_0010);
      // attribute-only size stays disabled
      wr(1, 0, 32'h0000_0008);
      look(32'h4010_0010);
      chk("R3 attr only", {31'd0, out_hit}, 32'd0);

      // register port corners
      rd("R1 readback", 2, 2, 32'h1234_0000);
      wr(2, 3, 32'hDEAD_BEEF);
      rd("R1 rsvd field", 2, 3, 32'd0);
      wr(6, 0, 32'hFFFF_FFF0);
      rd("R1 bad index", 6, 0, 32'd0);
      look(32'h9999_0000);
      chk("R1 bad index no hit", {31'd0, out_hit}, 32'd0);

      // R10: write and lookup on the same edge
      @(negedge clk);
      cfg_we = 1; cfg_win = 3; cfg_fld = 0; cfg_wdata = 32'hFF00_0000;
      in_valid = 1; in_addr = 32'h0055_0000;
      @(negedge clk);
      cfg_we = 0; in_valid = 0; #3;
      chk("R10 old value", {31'd0, out_hit}, 32'd0);
      look(32'h0055_0000);
      chk("R10 new value", {31'd0, out_hit}, 32'd1);

      // randomized traffic checked by the reference every cycle
      for (int n = 0; n < 2000; n++) begin
         @(negedge clk);
         cfg_we = ($urandom % 4) == 0;
         cfg_win = 3'($urandom % 8);
         cfg_fld = 2'($urandom % 4);
         if (cfg_fld == 0)
            cfg_wdata = (($urandom % 5) == 0) ? 32'd0
                      : ((32'hFFFF_FFFF << (4 + $urandom % 28)) | ($urandom & 32'h8));
         else
            cfg_wdata = $urandom;
         in_valid = ($urandom % 3) != 0;
         in_addr = ($urandom % 2) ? (mpb[$urandom % 6] ^ ($urandom & 32'h000F_FFFF)) : $urandom;
      end
      @(negedge clk);
      cfg_we = 0; in_valid = 0;
      repeat (2) @(negedge clk);
      running = 0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule